// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a separate outcome history for each set of branch addresses and uses that history to pick a two-bit confidence counter. A fetch stage presents a program counter on the lookup port. Within the same cycle it gets back a taken/not-taken guess, with no clock edge in between. When the branch later resolves, the execute stage presents the branch's program counter and its real outcome on the update port. Both tables then train on the next clock edge.

There are two storage structures. The first is a table of short history shift registers, one per branch set, selected by low program counter bits. The second is a pattern table of saturating two-bit counters. A pattern counter is selected by joining low program counter bits with the history that the first table returned. The default sizes are 128 history registers of 3 bits each, and 4096 counters (8 Kbit).

Top module: `lhbp_top`

## Requirements
- R1: After reset every pattern counter holds 01 (weakly not-taken) and every history register holds 000, so any lookup predicts not-taken until an update has been made.
- R2: The prediction is bit 1 of the pattern counter at index {pc[10:2], H}. Here H is the history register selected by pc[8:2], and it forms the three low index bits.
- R3: On an update, the selected counter moves up by one for a taken outcome and down by one for a not-taken outcome. It stays at 3 when already at 3, and at 0 when already at 0.
- R4: On an update, the history register selected by up_pc[8:2] shifts left by one. The outcome enters bit 0 (1 = taken) and the old bit 2 is dropped.
- R5: Program counter bits [1:0] have no effect. Bits above 10 have no effect on counter selection, and bits above 8 have no effect on history selection.
- R6: While up_valid is 0, neither table changes, whatever values up_pc and up_taken carry.
- R7: The counter trained by an update is the one indexed with the history value held before that same update.
- R8: A lookup made in the same cycle as an update to the same entries returns the pre-update prediction. The new state is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Program counter being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 32 | Program counter of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the block with its default parameters: 3 history bits, 7 history-select bits and 9 counter-select bits, which gives the full 4096-entry pattern table. These sizes let directed sequences train one branch to counter saturation in both directions and replay alternating patterns that only history selection can learn. They also let address aliases be formed in the ignored low bits, in the ignored upper bits, and in the bits that share a history register but not a counter. A long mixed phase then drives lookups and updates, often to the same address in the same cycle, against a reference model of both tables.

// File: rtl/lhbp_pkg.sv
package lhbp_pkg;

    // Two-bit saturating direction counter
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN   = 2'd0;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_RESET = 2'b01;   // weakly not-taken

    // Next counter value for a resolved outcome
    function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && (cur != CTR_MAX))
            nxt = cur + 2'd1;
        else if (!taken && (cur != CTR_MIN))
            nxt = cur - 2'd1;
        return nxt;
    endfunction

    // Direction bit of a counter
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/lhbp_hist_table.sv
module lhbp_hist_table #(
    parameter int HIST_BITS = 3,
    parameter int SEL_BITS  = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_BITS-1:0]  rd_a_sel,
    output logic [HIST_BITS-1:0] rd_a_hist,
    input  logic [SEL_BITS-1:0]  rd_b_sel,
    output logic [HIST_BITS-1:0] rd_b_hist,
    input  logic                 wr_en,
    input  logic [SEL_BITS-1:0]  wr_sel,
    input  logic                 wr_taken
);
    localparam int ENTRIES = 1 << SEL_BITS;

    logic [ENTRIES-1:0][HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0]              shifted;

    generate
        if (HIST_BITS == 1) begin : g_single
            assign shifted = wr_taken;
        end else begin : g_shift
            assign shifted = {hist_q[wr_sel][HIST_BITS-2:0], wr_taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (wr_en) begin
            hist_q[wr_sel] <= shifted;
        end
    end

    assign rd_a_hist = hist_q[rd_a_sel];
    assign rd_b_hist = hist_q[rd_b_sel];

    // R4: newest outcome lands in bit 0
    a_r4_newest_bit: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hist_q[$past(wr_sel)][0] == $past(wr_taken));

    // R6: no history change without an update
    a_r6_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(hist_q));

endmodule

// File: rtl/lhbp_pattern_table.sv
module lhbp_pattern_table
    import lhbp_pkg::*;
#(
    parameter int SEL_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_BITS-1:0] rd_sel,
    output ctr_t                rd_ctr,
    input  logic                wr_en,
    input  logic [SEL_BITS-1:0] wr_sel,
    input  logic                wr_taken
);
    localparam int ENTRIES = 1 << SEL_BITS;

    ctr_t [ENTRIES-1:0] ctr_q;
    ctr_t               wr_cur;
    ctr_t               wr_nxt;

    assign wr_cur = ctr_q[wr_sel];
    assign wr_nxt = ctr_next(wr_cur, wr_taken);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= {ENTRIES{CTR_RESET}};
        end else if (wr_en) begin
            ctr_q[wr_sel] <= wr_nxt;
        end
    end

    assign rd_ctr = ctr_q[rd_sel];

    // R3: a taken outcome never lowers the counter
    a_r3_taken_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=> ctr_q[$past(wr_sel)] >= $past(ctr_q[wr_sel]));

    // R3: a not-taken outcome never raises the counter
    a_r3_not_taken_down: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=> ctr_q[$past(wr_sel)] <= $past(ctr_q[wr_sel]));

    // R3: saturation at the top
    a_r3_hold_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_sel] == CTR_MAX) |=> ctr_q[$past(wr_sel)] == CTR_MAX);

    // R6: no counter change without an update
    a_r6_ctr_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/lhbp_top.sv
module lhbp_top
    import lhbp_pkg::*;
#(
    parameter int PC_W          = 32,
    parameter int ALIGN_BITS    = 2,
    parameter int HIST_BITS     = 3,
    parameter int HIST_SEL_BITS = 7,
    parameter int PC_SEL_BITS   = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int CTR_SEL_BITS = PC_SEL_BITS + HIST_BITS;
    localparam int PC_TOP       = ALIGN_BITS + PC_SEL_BITS;

    typedef struct packed {
        logic [HIST_SEL_BITS-1:0] hsel;
        logic [PC_SEL_BITS-1:0]   pbits;
    } addr_sel_t;

    addr_sel_t            lk_sel, up_sel;
    logic [HIST_BITS-1:0] lk_hist, up_hist;
    logic [CTR_SEL_BITS-1:0] lk_csel, up_csel;
    ctr_t                 lk_ctr;
    logic                 unused_pc_bits;

    assign lk_sel.hsel  = lk_pc[ALIGN_BITS +: HIST_SEL_BITS];
    assign lk_sel.pbits = lk_pc[ALIGN_BITS +: PC_SEL_BITS];
    assign up_sel.hsel  = up_pc[ALIGN_BITS +: HIST_SEL_BITS];
    assign up_sel.pbits = up_pc[ALIGN_BITS +: PC_SEL_BITS];

    assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_TOP], lk_pc[ALIGN_BITS-1:0],
                              up_pc[PC_W-1:PC_TOP], up_pc[ALIGN_BITS-1:0]};

    lhbp_hist_table #(
        .HIST_BITS (HIST_BITS),
        .SEL_BITS  (HIST_SEL_BITS)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .rd_a_sel  (lk_sel.hsel),
        .rd_a_hist (lk_hist),
        .rd_b_sel  (up_sel.hsel),
        .rd_b_hist (up_hist),
        .wr_en     (up_valid),
        .wr_sel    (up_sel.hsel),
        .wr_taken  (up_taken)
    );

    // Counter index: program counter bits above, history below
    assign lk_csel = {lk_sel.pbits, lk_hist};
    assign up_csel = {up_sel.pbits, up_hist};

    lhbp_pattern_table #(
        .SEL_BITS (CTR_SEL_BITS)
    ) u_pat (
        .clk      (clk),
        .rst      (rst),
        .rd_sel   (lk_csel),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_sel   (up_csel),
        .wr_taken (up_taken)
    );

    assign lk_taken = ctr_dir(lk_ctr);

endmodule

// File: tb/lhbp_top_tb.sv
module lhbp_top_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_pc;
    logic        lk_taken;
    logic        up_valid;
    logic [31:0] up_pc;
    logic        up_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit          exp;
        string       tag;
        logic [31:0] pc;
    } item_t;
    item_t sb_q[$];

    // Reference state
    bit [2:0] m_hist [128];
    bit [1:0] m_ctr  [4096];

    always #(CLK_P/2) clk = ~clk;

    lhbp_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken)
    );

    function automatic int hsel(input logic [31:0] pc);
        return int'((pc >> 2) & 32'h7F);
    endfunction

    function automatic int csel(input logic [31:0] pc);
        return int'((((pc >> 2) & 32'h1FF) << 3) | 32'(m_hist[hsel(pc)]));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_hist[i] = 3'b000;
        for (int i = 0; i < 4096; i++) m_ctr[i] = 2'b01;
    endtask

    // Driver: one cycle of stimulus, expected prediction pushed before training
    task automatic step(input logic [31:0] lpc, input bit uv,
                        input logic [31:0] upc, input bit ut, input string tag);
        item_t it;
        int ci, hi;
        @(negedge clk);
        lk_pc    = lpc;
        up_valid = uv;
        up_pc    = upc;
        up_taken = ut;
        it.exp = m_ctr[csel(lpc)][1];
        it.tag = tag;
        it.pc  = lpc;
        sb_q.push_back(it);
        if (uv) begin
            ci = csel(upc);
            hi = hsel(upc);
            if (ut && m_ctr[ci] != 2'd3) m_ctr[ci] = m_ctr[ci] + 2'd1;
            else if (!ut && m_ctr[ci] != 2'd0) m_ctr[ci] = m_ctr[ci] - 2'd1;
            m_hist[hi] = {m_hist[hi][1:0], ut};
        end
    endtask

    // Monitor: compares a quarter period after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (lk_taken !== it.exp) begin
                    fails++;
                    $display("FAIL %s pc=%h actual=%0b expected=%0b",
                             it.tag, it.pc, lk_taken, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [31:0] PA = 32'h0000_0100;
    localparam logic [31:0] PB = 32'h0000_0240;

    initial begin
        rst = 1'b1; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state predicts not-taken everywhere
        step(PA, 0, 0, 0, "R1");
        step(PB, 0, 0, 0, "R1");
        step(32'hFFFF_FFFC, 0, 0, 0, "R1");

        // R8: same-cycle lookup sees pre-update value
        step(PA, 1, PA, 1, "R8");
        step(PA, 0, 0, 0, "R7");

        // R3: train taken to saturation, then step down
        for (int i = 0; i < 8; i++) step(PA, 1, PA, 1, "R3");
        step(PA, 0, 0, 0, "R3");
        step(PA, 1, PA, 0, "R3");
        step(PA, 0, 0, 0, "R3");
        for (int i = 0; i < 8; i++) step(PA, 1, PA, 0, "R3");
        step(PA, 0, 0, 0, "R3");

        // R2, R4: alternating pattern learned through history
        for (int i = 0; i < 16; i++) step(PB, 1, PB, (i % 2) == 0, "R4");
        step(PB, 0, 0, 0, "R2");

        // R5: ignored and aliasing address bits
        step(PA | 32'h1, 0, 0, 0, "R5");
        step(PA | 32'h3, 0, 0, 0, "R5");
        step(PA + 32'h0000_0800, 0, 0, 0, "R5");
        step(PA + 32'h0000_0200, 0, 0, 0, "R5");
        step(PB + 32'h0001_0000, 0, 0, 0, "R5");

        // R6: updates without strobe leave state untouched
        for (int i = 0; i < 6; i++) step(PB, 0, PB, 1, "R6");
        for (int i = 0; i < 6; i++) step(PA, 0, PA, i[0], "R6");
        step(PB, 0, 0, 0, "R6");

        // R7, R8: mixed traffic over a small address set
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            bit t;
            a = {20'h0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 3)), 2'b00, 2'($urandom)};
            b = ($urandom_range(0, 1) == 1) ? a :
                {20'h0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 3)), 4'b0000};
            t = ($urandom_range(0, 3) != 0) ^ b[4];
            step(a, $urandom_range(0, 4) != 0, b, t, "R7");
        end

        @(negedge clk);
        up_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule